// File: doc/BRIEF.md
# Receive Character Buffer with Error Status Queue

This block sits behind a serial receive framer and holds incoming characters until a host pops them. Every character is stored together with its own two status flags: a framing-error indication supplied by the framer and an overrun indication produced here. The data queue and the status queue share their pointers, so a popped character and its status always belong together. The buffer is three entries deep by default.

If a character arrives while all entries are occupied and nothing is popped in that cycle, it does not wait and it is not dropped. It replaces the most recently written entry, and that entry's status is rewritten with the new character's framing flag plus an overrun mark. Two sticky error bits, one for framing and one for overrun, are set only when an affected character moves to the head of the queue and becomes readable. They stay set until the host writes a one to the matching clear input or the block is reset. An interrupt output combines the sticky bits with two enable inputs.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset, `not_empty`, `ferr_flag`, `ovr_flag` and `irq` are all 0.
- R2: Characters are read out in arrival order, and up to DEPTH (3) characters are held. `rd_data` shows the head character while `not_empty` is 1. A `rd_pop` pulse removes the head at the next clock edge.
- R3: A `rd_pop` pulse while the buffer is empty is ignored. A character pushed afterwards is read normally.
- R4: A character that arrives while the buffer holds DEPTH characters, with no pop in that cycle, replaces the most recently written character. The older characters are kept in order, and the occupancy stays at DEPTH.
- R5: A character that arrives in the same cycle as a pop of a full buffer is not an overrun. Both operations take effect, and no character is lost.
- R6: `ferr_flag` becomes 1 when a character received with `chr_ferr`=1 becomes the head entry. It does not become 1 while that character still waits behind older ones.
- R7: `ovr_flag` becomes 1 when an overwriting character becomes the head entry. It does not become 1 at the moment of the overwrite.
- R8: Once set, `ferr_flag` and `ovr_flag` stay 1 while later error-free characters pass through.
- R9: A 1 on `clr_ferr` or `clr_ovr` for one cycle clears only that flag at the next edge. A 0 on these inputs has no effect.
- R10: If a clear and a new set condition for the same flag fall in the same cycle, the flag ends up 1.
- R11: `irq` is 1 exactly when (`ferr_flag` and `ien_ferr`) or (`ovr_flag` and `ien_ovr`).
- R12: After an overrun, later characters are accepted and read out normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | DW (8) | Received character |
| chr_ferr | input | 1 | Framing error flag for the strobed character |
| rd_pop | input | 1 | Read strobe: removes the head character |
| rd_data | output | DW (8) | Head character |
| not_empty | output | 1 | At least one character is held |
| clr_ferr | input | 1 | Write-one-to-clear for the framing error bit |
| clr_ovr | input | 1 | Write-one-to-clear for the overrun bit |
| ien_ferr | input | 1 | Interrupt enable for the framing error bit |
| ien_ovr | input | 1 | Interrupt enable for the overrun bit |
| ferr_flag | output | 1 | Sticky framing error bit |
| ovr_flag | output | 1 | Sticky overrun bit |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can collide in one cycle. The first is a character strobe and a pop while the buffer is full, which must count as a normal push plus pop and not as an overrun. The second is a clear write and a head arrival carrying the same error, which must leave the flag set. The bench provokes each collision by raising both strobes between the same two clock edges. Its queue model applies the pop before the push and the clear before the set, and the read-out order and the flag values after the edge are compared against that model.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // Per-character status carried beside the data queue.
  typedef struct packed {
    logic ovr;
    logic ferr;
  } rxb_stat_t;

endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl #(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic          rd_pop,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic          ovr_now,
  output logic [PW-1:0] rd_idx,
  output logic [PW-1:0] nh_idx,
  output logic          arrive,
  output logic          not_empty,
  output logic [CW-1:0] occ
);

  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [PW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          full, empty, pop_ok, push_norm;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? LAST : p - PW'(1);
  endfunction

  always_comb begin
    full      = (cnt_q == FULLC);
    empty     = (cnt_q == '0);
    pop_ok    = rd_pop && !empty;
    push_norm = chr_valid && (!full || pop_ok);
    ovr_now   = chr_valid && full && !pop_ok;
    wr_en     = chr_valid;
    wr_idx    = ovr_now ? ptr_dec(wr_q) : wr_q;
    nh_idx    = pop_ok ? ptr_inc(rd_q) : rd_q;
    rd_n      = pop_ok ? ptr_inc(rd_q) : rd_q;
    wr_n      = push_norm ? ptr_inc(wr_q) : wr_q;
    case ({push_norm, pop_ok})
      2'b10:   cnt_n = cnt_q + CW'(1);
      2'b01:   cnt_n = cnt_q - CW'(1);
      default: cnt_n = cnt_q;
    endcase
    arrive = (cnt_n != '0) &&
             (pop_ok || (empty && push_norm) || (ovr_now && (wr_idx == rd_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_ok)             rd_q  <= rd_n;
      if (push_norm)          wr_q  <= wr_n;
      if (push_norm ^ pop_ok) cnt_q <= cnt_n;
    end
  end

  assign rd_idx    = rd_q;
  assign not_empty = !empty;
  assign occ       = cnt_q;

endmodule

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  rxb_stat_t     wr_stat,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [PW-1:0] st_idx,
  output rxb_stat_t     st_out
);

  logic [DW-1:0] data_q [DEPTH];
  rxb_stat_t     stat_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        stat_q[g] <= '0;
      end else if (sel) begin
        data_q[g] <= wr_data;
        stat_q[g] <= wr_stat;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    st_out  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PW'(i)) rd_data = data_q[i];
      if (st_idx == PW'(i)) st_out  = stat_q[i];
    end
  end

endmodule

// File: rtl/rxb_sticky.sv
module rxb_sticky
  import rxb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arrive,
  input  rxb_stat_t arr_stat,
  input  logic      clr_ferr,
  input  logic      clr_ovr,
  input  logic      ien_ferr,
  input  logic      ien_ovr,
  output logic      ferr_flag,
  output logic      ovr_flag,
  output logic      irq
);

  logic ferr_q, ferr_n, ovr_q, ovr_n;

  always_comb begin
    ferr_n = (ferr_q && !clr_ferr) || (arrive && arr_stat.ferr);
    ovr_n  = (ovr_q  && !clr_ovr)  || (arrive && arr_stat.ovr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ferr_q <= ferr_n;
      ovr_q  <= ovr_n;
    end
  end

  assign ferr_flag = ferr_q;
  assign ovr_flag  = ovr_q;
  assign irq       = (ferr_q && ien_ferr) || (ovr_q && ien_ovr);

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [DW-1:0] chr_data,
  input  logic          chr_ferr,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          not_empty,
  input  logic          clr_ferr,
  input  logic          clr_ovr,
  input  logic          ien_ferr,
  input  logic          ien_ovr,
  output logic          ferr_flag,
  output logic          ovr_flag,
  output logic          irq
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_en, ovr_now, arrive;
  logic [PW-1:0] wr_idx, rd_idx, nh_idx;
  logic [CW-1:0] occ;
  rxb_stat_t     in_stat, nh_stat, arr_stat;

  rxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chr_valid (chr_valid),
    .rd_pop    (rd_pop),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .ovr_now   (ovr_now),
    .rd_idx    (rd_idx),
    .nh_idx    (nh_idx),
    .arrive    (arrive),
    .not_empty (not_empty),
    .occ       (occ)
  );

  always_comb begin
    in_stat.ferr = chr_ferr;
    in_stat.ovr  = ovr_now;
    // The entry becoming head may be the one written in this same cycle.
    arr_stat = (wr_en && (wr_idx == nh_idx)) ? in_stat : nh_stat;
  end

  rxb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (chr_data),
    .wr_stat (in_stat),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .st_idx  (nh_idx),
    .st_out  (nh_stat)
  );

  rxb_sticky u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive    (arrive),
    .arr_stat  (arr_stat),
    .clr_ferr  (clr_ferr),
    .clr_ovr   (clr_ovr),
    .ien_ferr  (ien_ferr),
    .ien_ovr   (ien_ovr),
    .ferr_flag (ferr_flag),
    .ovr_flag  (ovr_flag),
    .irq       (irq)
  );

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chr_valid,
  input logic          rd_pop,
  input logic          clr_ferr,
  input logic          clr_ovr,
  input logic          not_empty,
  input logic [DW-1:0] rd_data,
  input logic          ferr_flag,
  input logic          ovr_flag,
  input logic          arrive,
  input logic          arr_ferr,
  input logic          arr_ovr,
  input logic [CW-1:0] occ
);

  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && rd_pop && !chr_valid) |=> !not_empty); // R3

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (DEPTH > 1 && not_empty && !rd_pop) |=> $stable(rd_data)); // R2

  AST_OVERRUN_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULLC && chr_valid && !rd_pop) |=> occ == FULLC); // R4

  AST_FERR_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && arr_ferr) |=> ferr_flag); // R6

  AST_OVR_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && arr_ovr) |=> ovr_flag); // R7

  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_flag && !clr_ferr) |=> ferr_flag); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |=> ovr_flag); // R8

  AST_FERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ferr && !(arrive && arr_ferr)) |=> !ferr_flag); // R9

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !(arrive && arr_ovr)) |=> !ovr_flag); // R9

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ferr && arrive && arr_ferr) |=> ferr_flag); // R10

endmodule

bind rx_char_buffer rxb_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chr_valid (chr_valid),
  .rd_pop    (rd_pop),
  .clr_ferr  (clr_ferr),
  .clr_ovr   (clr_ovr),
  .not_empty (not_empty),
  .rd_data   (rd_data),
  .ferr_flag (ferr_flag),
  .ovr_flag  (ovr_flag),
  .arrive    (arrive),
  .arr_ferr  (arr_stat.ferr),
  .arr_ovr   (arr_stat.ovr),
  .occ       (occ)
);

// File: tb/tb_rx_char_buffer.sv
module tb_rx_char_buffer;

  localparam int DW  = 8;
  localparam int DEP = 3;

  logic          clk, rst_n;
  logic          chr_valid, chr_ferr, rd_pop;
  logic [DW-1:0] chr_data, rd_data;
  logic          not_empty, clr_ferr, clr_ovr, ien_ferr, ien_ovr;
  logic          ferr_flag, ovr_flag, irq;

  rx_char_buffer #(.DW(DW), .DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_ferr(chr_ferr), .rd_pop(rd_pop), .rd_data(rd_data),
    .not_empty(not_empty), .clr_ferr(clr_ferr), .clr_ovr(clr_ovr),
    .ien_ferr(ien_ferr), .ien_ovr(ien_ovr), .ferr_flag(ferr_flag),
    .ovr_flag(ovr_flag), .irq(irq)
  );

  typedef struct packed {
    logic [DW-1:0] d;
    logic          fe;
    logic          ov;
  } item_t;

  item_t exp_q[$];
  bit    exp_fe, exp_ov;
  int    total, bad;
  string cur_tag;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Monitor: compares each popped character against the scoreboard queue.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rd_pop && not_empty) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected read", int'(rd_data), -1);
      end else begin
        chk(rd_data == exp_q[0].d, cur_tag, "read data",
            int'(rd_data), int'(exp_q[0].d));
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic check_state(input string tag);
    bit ei;
    ei = (exp_fe && ien_ferr) || (exp_ov && ien_ovr);
    chk(not_empty == (exp_q.size() > 0), tag, "not_empty",
        int'(not_empty), int'(exp_q.size() > 0));
    chk(ferr_flag == exp_fe, tag, "ferr_flag", int'(ferr_flag), int'(exp_fe));
    chk(ovr_flag == exp_ov, tag, "ovr_flag", int'(ovr_flag), int'(exp_ov));
    chk(irq == ei, tag, "irq", int'(irq), int'(ei));
  endtask

  // Driver: one cycle of stimulus, then scoreboard update and state check.
  task automatic drive(input bit do_push, input logic [DW-1:0] d,
                       input bit fe, input bit do_pop, input bit cf,
                       input bit co, input string tag);
    int  sz;
    bit  popped, ovr, arr;
    item_t it;
    sz      = exp_q.size();
    popped  = do_pop && (sz > 0);
    ovr     = do_push && (sz == DEP) && !popped;
    cur_tag = tag;
    chr_valid = do_push; chr_data = d; chr_ferr = fe;
    rd_pop = do_pop; clr_ferr = cf; clr_ovr = co;
    @(negedge clk);
    chr_valid = 1'b0; chr_ferr = 1'b0; rd_pop = 1'b0;
    clr_ferr = 1'b0; clr_ovr = 1'b0;
    if (do_push) begin
      it.d = d; it.fe = fe; it.ov = ovr;
      if (ovr) exp_q[exp_q.size()-1] = it;
      else     exp_q.push_back(it);
    end
    arr = popped ? (exp_q.size() > 0) : (sz == 0 && do_push);
    if (cf) exp_fe = 1'b0;
    if (co) exp_ov = 1'b0;
    if (arr) begin
      if (exp_q[0].fe) exp_fe = 1'b1;
      if (exp_q[0].ov) exp_ov = 1'b1;
    end
    check_state(tag);
    if (not_empty && exp_q.size() > 0)
      chk(rd_data == exp_q[0].d, tag, "head data",
          int'(rd_data), int'(exp_q[0].d));
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; exp_fe = 0; exp_ov = 0; cur_tag = "R1";
    chr_valid = 0; chr_data = '0; chr_ferr = 0; rd_pop = 0;
    clr_ferr = 0; clr_ovr = 0; ien_ferr = 0; ien_ovr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");

    // R2: order and depth
    drive(1, 8'h11, 0, 0, 0, 0, "R2");
    drive(1, 8'h22, 0, 0, 0, 0, "R2");
    drive(1, 8'h33, 0, 0, 0, 0, "R2");
    drive(0, 0, 0, 1, 0, 0, "R2");
    drive(0, 0, 0, 1, 0, 0, "R2");
    drive(0, 0, 0, 1, 0, 0, "R2");

    // R3: pop on empty ignored
    drive(0, 0, 0, 1, 0, 0, "R3");
    drive(1, 8'h44, 0, 0, 0, 0, "R3");
    drive(0, 0, 0, 1, 0, 0, "R3");

    // R6: framing error flagged only once its character is at the head
    drive(1, 8'h51, 0, 0, 0, 0, "R6");
    drive(1, 8'h52, 1, 0, 0, 0, "R6");
    chk(ferr_flag == 1'b0, "R6", "ferr before head", int'(ferr_flag), 0);
    drive(0, 0, 0, 1, 0, 0, "R6");
    chk(ferr_flag == 1'b1, "R6", "ferr at head", int'(ferr_flag), 1);
    drive(0, 0, 0, 1, 0, 0, "R6");

    // R8 and R11: sticky through a clean character, interrupt gating
    drive(1, 8'h61, 0, 0, 0, 0, "R8");
    drive(0, 0, 0, 1, 0, 0, "R8");
    ien_ferr = 1'b1;
    #1 chk(irq == 1'b1, "R11", "irq enabled", int'(irq), 1);
    ien_ferr = 1'b0;
    #1 chk(irq == 1'b0, "R11", "irq disabled", int'(irq), 0);

    // R9: clearing the other bit leaves this one, then clear it
    drive(0, 0, 0, 0, 0, 1, "R9");
    drive(0, 0, 0, 0, 1, 0, "R9");

    // R4 and R7: overrun replaces the newest entry
    drive(1, 8'h71, 0, 0, 0, 0, "R4");
    drive(1, 8'h72, 0, 0, 0, 0, "R4");
    drive(1, 8'h73, 0, 0, 0, 0, "R4");
    drive(1, 8'h74, 0, 0, 0, 0, "R4");
    chk(ovr_flag == 1'b0, "R7", "ovr before head", int'(ovr_flag), 0);
    drive(0, 0, 0, 1, 0, 0, "R4");
    drive(0, 0, 0, 1, 0, 0, "R7");
    chk(ovr_flag == 1'b1, "R7", "ovr at head", int'(ovr_flag), 1);
    chk(rd_data == 8'h74, "R4", "overwriter at head", int'(rd_data), 'h74);
    ien_ovr = 1'b1;
    drive(0, 0, 0, 1, 0, 0, "R11");
    ien_ovr = 1'b0;

    // R12: normal traffic after overrun
    drive(1, 8'h81, 0, 0, 0, 0, "R12");
    drive(1, 8'h82, 0, 0, 0, 0, "R12");
    drive(0, 0, 0, 1, 0, 0, "R12");
    drive(0, 0, 0, 1, 0, 0, "R12");
    drive(0, 0, 0, 0, 0, 1, "R9");

    // R10: clear and new framing error arrival in the same cycle
    drive(1, 8'h91, 1, 0, 0, 0, "R10");
    drive(1, 8'h92, 1, 0, 0, 0, "R10");
    drive(0, 0, 0, 1, 1, 0, "R10");
    chk(ferr_flag == 1'b1, "R10", "set beats clear", int'(ferr_flag), 1);
    drive(0, 0, 0, 1, 1, 0, "R10");

    // R5: push and pop together on a full buffer
    drive(1, 8'hA1, 0, 0, 0, 0, "R5");
    drive(1, 8'hA2, 0, 0, 0, 0, "R5");
    drive(1, 8'hA3, 0, 0, 0, 0, "R5");
    drive(1, 8'hA4, 0, 1, 0, 0, "R5");
    drive(0, 0, 0, 1, 0, 0, "R5");
    drive(0, 0, 0, 1, 0, 0, "R5");
    drive(0, 0, 0, 1, 0, 0, "R5");
    chk(ovr_flag == 1'b0, "R5", "no overrun", int'(ovr_flag), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule